// File: doc/BRIEF.md
# Logarithmic-domain arithmetic unit

This block does arithmetic on real numbers held as a sign plus a base-2 exponent. The exponent is a fixed-point value stored in sign-magnitude form. It has `I_BITS` integer bits and `F_BITS` fraction bits. Multiplying or dividing two values only adds or subtracts their exponents, so the block contains no multiplier. Adding or subtracting two values keeps the larger exponent and adds a correction term to it. That term is read from one of two tables, chosen by whether the operand signs agree. The tables are filled when the design is elaborated, and each is indexed by the exponent difference.

Operands are accepted on a valid/ready handshake together with a two-bit opcode. The result, a saturation bit and a divide-by-zero bit appear exactly two clock cycles after the operands are accepted. The unit accepts a new operation every cycle and has no output backpressure. A dedicated zero flag in each word covers the one value that the exponent form cannot reach.

Top module: `lns_alu`

## Requirements
- R1: A word is `{zero, vsign, esign, emag}`. `zero` is bit W-1. `vsign` is bit W-2 (1 means negative). `esign` is bit W-3 (1 means a negative exponent). `emag` is bits W-4..0, the exponent magnitude, of which the low `F_BITS` bits are fraction. The value is (-1)^vsign · 2^e. An operand with `zero`=1 is zero, whatever its other bits hold. A zero result is exactly `1` followed by all zeros, and a result exponent of zero is encoded with `esign`=0.
- R2: Opcode 0 multiplies, 1 divides, 2 adds, 3 subtracts (a − b).
- R3: Multiply of two non-zero operands gives exponent ea+eb and sign vsign_a XOR vsign_b.
- R4: Divide of two non-zero operands gives exponent ea−eb and sign vsign_a XOR vsign_b.
- R5: Multiply with either operand zero gives zero. Divide with a zero dividend and a non-zero divisor gives zero. Divide by zero sets `out_div0`, clears the zero flag and gives sign vsign_a XOR vsign_b with the largest positive exponent.
- R6: Add, non-zero operands, equal signs. The result takes that sign and has exponent max(ea,eb) + c/2^F. Here c = round(2^F·log2(1+2^−d)) and d = |ea−eb|.
- R7: Add, non-zero operands, different signs. Equal exponents give zero. Otherwise the result takes the sign of the operand with the larger exponent and has exponent max(ea,eb) − c/2^F, where c = round(−2^F·log2(1−2^−d)).
- R8: Subtract equals add with the sign of b inverted.
- R9: When d ≥ `TBL_SPAN` the correction is zero and the result is the operand with the larger exponent.
- R10: Add or subtract with one zero operand returns the other operand (b negated for subtract). Two zero operands give zero.
- R11: A result exponent above the largest magnitude saturates to that magnitude (positive exponent) and sets `out_sat`. One below minus the largest magnitude gives zero and sets `out_sat`. Otherwise `out_sat` is 0.
- R12: During reset `in_ready` and `out_valid` are 0. `in_ready` is 1 from the first clock edge after reset. An operation accepted at edge E shows `out_valid`=1 with its result after edge E+1, for one cycle per operation. Back-to-back operations produce back-to-back results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands and opcode are presented |
| in_ready | output | 1 | Unit can accept an operation |
| in_op | input | 2 | Opcode (R2) |
| in_a | input | W=I_BITS+F_BITS+3 | First operand |
| in_b | input | W | Second operand |
| out_valid | output | 1 | Result is valid this cycle |
| out_res | output | W | Result word |
| out_sat | output | 1 | Exponent range exceeded |
| out_div0 | output | 1 | Division by zero |

## Verification
The hardest situation to reach from the ports is a subtraction near the bottom of the range. There the table correction for a tiny exponent difference pushes the exponent below the representable floor. To get there, the bench subtracts two operands of equal sign whose exponents are near the negative limit and one fraction step apart. Another hard case is the cut-off edge of the table, reached with exponent differences exactly at the span and one step below it, in both operand orders. A seeded sweep of exponents clustered close together then checks every opcode against a bench-side model built from the requirements. Back-to-back issue confirms that results stream out one per cycle.

// File: rtl/lns_pkg.sv
// Package: shared opcode and result-class types for the log-domain unit.
// Assumes: opcode encoding is fixed by the block requirements.
package lns_pkg;
    typedef enum logic [1:0] {
        OP_MUL = 2'd0,
        OP_DIV = 2'd1,
        OP_ADD = 2'd2,
        OP_SUB = 2'd3
    } lns_op_e;

    typedef enum logic [1:0] {
        CLS_NORMAL = 2'd0,
        CLS_ZERO   = 2'd1,
        CLS_DIV0   = 2'd2
    } lns_cls_e;
endpackage

// File: rtl/lns_corr_rom.sv
// Module: correction table for log-domain add (SUBTRACT=0) or subtract (SUBTRACT=1).
// Entry i holds round(2^F * |log2(1 +/- 2^(-i/2^F))|), filled at elaboration.
// Assumes: diff is the non-negative exponent difference in fraction units;
// differences at or beyond TBL_SPAN give zero. Entry 0 of the subtract table
// is unused (exact cancellation is handled upstream).
module lns_corr_rom #(
    parameter int F_BITS   = 4,
    parameter int TBL_SPAN = 8,
    parameter int DW       = 9,
    parameter int CW       = 8,
    parameter bit SUBTRACT = 1'b0
) (
    input  logic [DW-1:0] diff,
    output logic [CW-1:0] corr
);
    localparam int TBL_N = TBL_SPAN << F_BITS;
    localparam int IDXW  = $clog2(TBL_N);
    localparam int ONE   = 1 << F_BITS;

    logic [CW-1:0] tbl [TBL_N];

    for (genvar i = 0; i < TBL_N; i++) begin : g_ent
        localparam real XD = real'(i) / real'(ONE);
        localparam real XS = (i == 0) ? 1.0 : XD;
        localparam real VA = $ln(1.0 + $pow(2.0, -XD)) / $ln(2.0);
        localparam real VS = -$ln(1.0 - $pow(2.0, -XS)) / $ln(2.0);
        localparam int  QV = (SUBTRACT && i == 0) ? 0 :
                             $rtoi($floor((SUBTRACT ? VS : VA) * real'(ONE) + 0.5));
        assign tbl[i] = CW'(QV);
    end

    // Table read with out-of-span forcing to zero.
    always_comb begin
        if (diff < DW'(TBL_N)) corr = tbl[diff[IDXW-1:0]];
        else                   corr = '0;
        if (!SUBTRACT && !$isunknown(corr)) begin
            p_add_corr_bound_r6: assert (corr <= CW'(ONE))
                else $error("add correction above one");
        end
    end
endmodule

// File: rtl/lns_prep.sv
// Module: stage-one datapath. Decodes operands, classifies special cases,
// orders add/subtract operands so the larger exponent leads, forms the
// exponent difference and looks up the correction term.
// Assumes: operand words follow the R1 layout; output is combinational.
module lns_prep
    import lns_pkg::*;
#(
    parameter int I_BITS   = 4,
    parameter int F_BITS   = 4,
    parameter int TBL_SPAN = 8,
    localparam int MW = I_BITS + F_BITS,
    localparam int W  = MW + 3,
    localparam int EW = MW + 2
) (
    input  logic [1:0]           op,
    input  logic [W-1:0]         opnd_a,
    input  logic [W-1:0]         opnd_b,
    output lns_cls_e             cls,
    output logic                 sign,
    output logic signed [EW-1:0] base,
    output logic [MW-1:0]        corr,
    output logic                 corr_neg
);
    localparam int DW = EW - 1;

    function automatic logic signed [EW-1:0] exp_of(input logic [W-1:0] v);
        logic signed [EW-1:0] m;
        m = $signed({2'b00, v[MW-1:0]});
        return v[MW] ? -m : m;
    endfunction

    logic                 za, zb, sa, sb_eff, a_lead;
    logic signed [EW-1:0] ea, eb, ex, ey, diff;
    logic                 sx, sy;
    logic [DW-1:0]        dmag;
    logic [MW-1:0]        c_add, c_sub;

    // Field decode and operand ordering for the add/subtract path.
    always_comb begin
        za     = opnd_a[W-1];
        zb     = opnd_b[W-1];
        sa     = opnd_a[W-2];
        sb_eff = opnd_b[W-2] ^ (op == OP_SUB);
        ea     = exp_of(opnd_a);
        eb     = exp_of(opnd_b);
        a_lead = (ea >= eb);
        ex     = a_lead ? ea : eb;
        ey     = a_lead ? eb : ea;
        sx     = a_lead ? sa : sb_eff;
        sy     = a_lead ? sb_eff : sa;
        diff   = ex - ey;
        dmag   = diff[DW-1:0];
    end

    lns_corr_rom #(.F_BITS(F_BITS), .TBL_SPAN(TBL_SPAN), .DW(DW), .CW(MW), .SUBTRACT(1'b0))
        u_rom_add (.diff(dmag), .corr(c_add));
    lns_corr_rom #(.F_BITS(F_BITS), .TBL_SPAN(TBL_SPAN), .DW(DW), .CW(MW), .SUBTRACT(1'b1))
        u_rom_sub (.diff(dmag), .corr(c_sub));

    // Per-opcode selection of class, sign, base exponent and correction.
    always_comb begin
        cls      = CLS_NORMAL;
        sign     = 1'b0;
        base     = '0;
        corr     = '0;
        corr_neg = 1'b0;
        case (op)
            OP_MUL: begin
                if (za || zb) cls = CLS_ZERO;
                else begin
                    sign = sa ^ opnd_b[W-2];
                    base = ea + eb;
                end
            end
            OP_DIV: begin
                sign = sa ^ opnd_b[W-2];
                if (zb)      cls = CLS_DIV0;
                else if (za) cls = CLS_ZERO;
                else         base = ea - eb;
            end
            default: begin
                if (za && zb) cls = CLS_ZERO;
                else if (za) begin
                    sign = sb_eff;
                    base = eb;
                end else if (zb) begin
                    sign = sa;
                    base = ea;
                end else if (sx == sy) begin
                    sign = sx;
                    base = ex;
                    corr = c_add;
                end else if (dmag == '0) begin
                    cls = CLS_ZERO;
                end else begin
                    sign     = sx;
                    base     = ex;
                    corr     = c_sub;
                    corr_neg = 1'b1;
                end
            end
        endcase
        if (op[1] && !za && !zb) begin
            p_swap_order_r6: assert (!diff[EW-1])
                else $error("ordered exponent difference negative");
        end
    end
endmodule

// File: rtl/lns_pack.sv
// Module: stage-two datapath. Applies the correction to the base exponent,
// saturates to the representable range and encodes the result word.
// Assumes: base and corr come from lns_prep (registered in between).
module lns_pack
    import lns_pkg::*;
#(
    parameter int I_BITS = 4,
    parameter int F_BITS = 4,
    localparam int MW = I_BITS + F_BITS,
    localparam int W  = MW + 3,
    localparam int EW = MW + 2
) (
    input  lns_cls_e             cls,
    input  logic                 sign,
    input  logic signed [EW-1:0] base,
    input  logic [MW-1:0]        corr,
    input  logic                 corr_neg,
    output logic [W-1:0]         res,
    output logic                 sat,
    output logic                 div0
);
    localparam int SW = EW + 1;
    localparam logic signed [SW-1:0] EMAX = SW'((2 ** MW) - 1);

    logic signed [SW-1:0] cext, sum, mag;

    // Final exponent adder, range check and word encode.
    always_comb begin
        cext = $signed({{(SW-MW){1'b0}}, corr});
        sum  = $signed({base[EW-1], base}) + (corr_neg ? -cext : cext);
        mag  = (sum < 0) ? -sum : sum;
        sat  = 1'b0;
        div0 = 1'b0;
        case (cls)
            CLS_ZERO: res = {1'b1, {(W-1){1'b0}}};
            CLS_DIV0: begin
                res  = {1'b0, sign, 1'b0, EMAX[MW-1:0]};
                div0 = 1'b1;
            end
            default: begin
                if (sum > EMAX) begin
                    res = {1'b0, sign, 1'b0, EMAX[MW-1:0]};
                    sat = 1'b1;
                end else if (sum < -EMAX) begin
                    res = {1'b1, {(W-1){1'b0}}};
                    sat = 1'b1;
                end else begin
                    res = {1'b0, sign, (sum < 0), mag[MW-1:0]};
                end
            end
        endcase
        if (!$isunknown({sat, div0})) begin
            p_flag_excl_r11: assert (!(sat && div0))
                else $error("saturation and divide-by-zero together");
        end
    end
endmodule

// File: rtl/lns_alu.sv
// Module: top of the log-domain arithmetic unit. Two register stages:
// stage one captures decode/ordering/lookup, stage two captures the final
// encoded result. Accepts one operation per cycle; no output backpressure.
// Assumes: synchronous active-low reset; inputs stable around the edge.
module lns_alu
    import lns_pkg::*;
#(
    parameter int I_BITS   = 4,
    parameter int F_BITS   = 4,
    parameter int TBL_SPAN = 8,
    localparam int MW = I_BITS + F_BITS,
    localparam int W  = MW + 3,
    localparam int EW = MW + 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [1:0]   in_op,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    output logic         out_valid,
    output logic [W-1:0] out_res,
    output logic         out_sat,
    output logic         out_div0
);
    logic                 accept;
    lns_cls_e             p_cls, s1_cls;
    logic                 p_sign, s1_sign, p_neg, s1_neg, s1_valid;
    logic signed [EW-1:0] p_base, s1_base;
    logic [MW-1:0]        p_corr, s1_corr;
    logic [W-1:0]         f_res;
    logic                 f_sat, f_div0;

    assign accept = in_valid && in_ready;

    lns_prep #(.I_BITS(I_BITS), .F_BITS(F_BITS), .TBL_SPAN(TBL_SPAN)) u_prep (
        .op(in_op), .opnd_a(in_a), .opnd_b(in_b),
        .cls(p_cls), .sign(p_sign), .base(p_base), .corr(p_corr), .corr_neg(p_neg)
    );

    // Ready goes high one edge after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) in_ready <= 1'b0;
        else        in_ready <= 1'b1;
    end

    // Stage one: capture the ordered operands and looked-up correction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_cls   <= CLS_ZERO;
            s1_sign  <= 1'b0;
            s1_base  <= '0;
            s1_corr  <= '0;
            s1_neg   <= 1'b0;
        end else begin
            s1_valid <= accept;
            if (accept) begin
                s1_cls  <= p_cls;
                s1_sign <= p_sign;
                s1_base <= p_base;
                s1_corr <= p_corr;
                s1_neg  <= p_neg;
            end
        end
    end

    lns_pack #(.I_BITS(I_BITS), .F_BITS(F_BITS)) u_pack (
        .cls(s1_cls), .sign(s1_sign), .base(s1_base), .corr(s1_corr), .corr_neg(s1_neg),
        .res(f_res), .sat(f_sat), .div0(f_div0)
    );

    // Stage two: register the encoded result and its flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_res   <= '0;
            out_sat   <= 1'b0;
            out_div0  <= 1'b0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_res  <= f_res;
                out_sat  <= f_sat;
                out_div0 <= f_div0;
            end
        end
    end

    p_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ##1 out_valid) else $error("result not two cycles after accept");

    p_no_spurious_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid) else $error("result without an operation");

    p_mul_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_op == OP_MUL && (in_a[W-1] || in_b[W-1]))
        |=> ##1 (out_res[W-1] && !out_sat)) else $error("multiply by zero not zero");

    p_div0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_op == OP_DIV && in_b[W-1])
        |=> ##1 (out_div0 && !out_res[W-1])) else $error("divide by zero not flagged");

    p_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_op == OP_ADD && !in_a[W-1] && !in_b[W-1]
         && (in_a[W-2] != in_b[W-2]) && (in_a[W-3:0] == in_b[W-3:0]))
        |=> ##1 out_res[W-1]) else $error("exact cancellation not zero");
endmodule

// File: tb/lns_alu_bench.sv
// Directed bench for lns_alu: one task per scenario, each checking its results.
module lns_alu_bench;
    localparam int I_BITS = 4;
    localparam int F_BITS = 4;
    localparam int SPAN   = 8;
    localparam int MW     = I_BITS + F_BITS;
    localparam int W      = MW + 3;
    localparam int EMAX   = (2 ** MW) - 1;
    localparam logic [W-1:0] ZW = {1'b1, {(W-1){1'b0}}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [1:0]   in_op = 2'd0;
    logic [W-1:0] in_a = '0;
    logic [W-1:0] in_b = '0;
    logic         out_valid;
    logic [W-1:0] out_res;
    logic         out_sat, out_div0;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    lns_alu #(.I_BITS(I_BITS), .F_BITS(F_BITS), .TBL_SPAN(SPAN)) u_lns_alu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
        .out_res(out_res), .out_sat(out_sat), .out_div0(out_div0)
    );

    function automatic logic [W-1:0] mk(input bit s, input int e);
        int m;
        m = (e < 0) ? -e : e;
        return {1'b0, s, (e < 0), MW'(m)};
    endfunction

    function automatic int q_add(input int d);
        real x;
        if (d >= (SPAN << F_BITS)) return 0;
        x = real'(d) / real'(1 << F_BITS);
        return $rtoi($floor($ln(1.0 + $pow(2.0, -x)) / $ln(2.0) * real'(1 << F_BITS) + 0.5));
    endfunction

    function automatic int q_sub(input int d);
        real x;
        if (d >= (SPAN << F_BITS)) return 0;
        x = real'(d) / real'(1 << F_BITS);
        return $rtoi($floor(-$ln(1.0 - $pow(2.0, -x)) / $ln(2.0) * real'(1 << F_BITS) + 0.5));
    endfunction

    function automatic int ex_of(input logic [W-1:0] v);
        int m;
        m = int'(v[MW-1:0]);
        return v[MW] ? -m : m;
    endfunction

    function automatic logic [W+1:0] fin(input bit s, input int e);
        if (e > EMAX)  return {1'b0, s, 1'b0, MW'(EMAX), 1'b1, 1'b0};
        if (e < -EMAX) return {ZW, 1'b1, 1'b0};
        return {mk(s, e), 1'b0, 1'b0};
    endfunction

    // Requirement-level model returning {result, sat, div0}.
    function automatic logic [W+1:0] model(input logic [1:0] op, input logic [W-1:0] a, b);
        bit za, zb, sa, sb;
        int ea, eb, d, ex;
        bit sx, sy;
        za = a[W-1]; zb = b[W-1]; sa = a[W-2]; sb = b[W-2];
        ea = ex_of(a); eb = ex_of(b);
        case (op)
            2'd0: begin
                if (za || zb) return {ZW, 2'b00};
                return fin(sa ^ sb, ea + eb);
            end
            2'd1: begin
                if (zb) return {1'b0, sa ^ sb, 1'b0, MW'(EMAX), 2'b01};
                if (za) return {ZW, 2'b00};
                return fin(sa ^ sb, ea - eb);
            end
            default: begin
                if (op == 2'd3) sb = ~sb;
                if (za && zb) return {ZW, 2'b00};
                if (za) return fin(sb, eb);
                if (zb) return fin(sa, ea);
                if (ea >= eb) begin ex = ea; sx = sa; sy = sb; d = ea - eb; end
                else          begin ex = eb; sx = sb; sy = sa; d = eb - ea; end
                if (sx == sy) return fin(sx, ex + q_add(d));
                if (d == 0)   return {ZW, 2'b00};
                return fin(sx, ex - q_sub(d));
            end
        endcase
    endfunction

    task automatic chk(input string tag, input logic [W+2:0] act, input logic [W+2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Issue one operation; check latency and {res,sat,div0}.
    task automatic op_chk(input string tag, input logic [1:0] op, input logic [W-1:0] a, b,
                          input logic [W+1:0] exp);
        logic lat_ok;
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        lat_ok = (out_valid == 1'b0);
        @(negedge clk);
        lat_ok = lat_ok && out_valid;
        chk(tag, {lat_ok, out_res, out_sat, out_div0}, {1'b1, exp});
    endtask

    task automatic op_mdl(input string tag, input logic [1:0] op, input logic [W-1:0] a, b);
        op_chk(tag, op, a, b, model(op, a, b));
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R12 reset state", {{(W+1){1'b0}}, in_ready, out_valid}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 ready after reset", {{(W+1){1'b0}}, in_ready, out_valid}, {{(W+1){1'b0}}, 2'b10});
    endtask

    task automatic t_opcodes();
        op_chk("R2 opcode 0", 2'd0, mk(0, 24), mk(0, 8), {mk(0, 32), 2'b00});
        op_chk("R2 opcode 1", 2'd1, mk(0, 24), mk(0, 8), {mk(0, 16), 2'b00});
        op_chk("R2 opcode 2", 2'd2, mk(0, 16), mk(0, 16), {mk(0, 32), 2'b00});
        op_chk("R2 opcode 3", 2'd3, mk(0, 16), mk(0, 16), {ZW, 2'b00});
    endtask

    task automatic t_muldiv();
        op_chk("R3 mul signs", 2'd0, mk(0, 24), mk(1, -4), {mk(1, 20), 2'b00});
        op_chk("R3 mul neg-neg", 2'd0, mk(1, -30), mk(1, -5), {mk(0, -35), 2'b00});
        op_chk("R1 zero exponent canonical", 2'd0, mk(1, 8), mk(0, -8), {mk(1, 0), 2'b00});
        op_chk("R4 div", 2'd1, mk(0, 24), mk(1, -4), {mk(1, 28), 2'b00});
        op_chk("R4 div to negative", 2'd1, mk(1, -10), mk(1, 7), {mk(0, -17), 2'b00});
    endtask

    task automatic t_zero_muldiv();
        op_chk("R5 mul zero a", 2'd0, ZW, mk(1, 40), {ZW, 2'b00});
        op_chk("R1 R5 zero with stray bits", 2'd0, mk(1, 40), {1'b1, 1'b1, 1'b1, MW'(77)}, {ZW, 2'b00});
        op_chk("R5 div zero dividend", 2'd1, ZW, mk(0, 3), {ZW, 2'b00});
        op_chk("R5 div by zero", 2'd1, mk(1, 5), ZW, {1'b0, 1'b1, 1'b0, MW'(EMAX), 2'b01});
    endtask

    task automatic t_add_same();
        op_chk("R6 equal exps", 2'd2, mk(0, 16), mk(0, 16), {mk(0, 32), 2'b00});
        op_chk("R6 d=1.0 swapped", 2'd2, mk(0, 16), mk(0, 32), {mk(0, 41), 2'b00});
        op_chk("R6 both negative", 2'd2, mk(1, 16), mk(1, 16), {mk(1, 32), 2'b00});
    endtask

    task automatic t_add_opp();
        op_chk("R7 4-2", 2'd2, mk(0, 32), mk(1, 16), {mk(0, 16), 2'b00});
        op_chk("R7 sign of larger", 2'd2, mk(1, 32), mk(0, 16), {mk(1, 16), 2'b00});
        op_chk("R7 cancel", 2'd2, mk(0, 10), mk(1, 10), {ZW, 2'b00});
        op_chk("R7 one step apart", 2'd2, mk(0, 0), mk(1, -1), {mk(0, -73), 2'b00});
    endtask

    task automatic t_sub();
        op_chk("R8 sub equal", 2'd3, mk(0, 32), mk(0, 32), {ZW, 2'b00});
        op_chk("R8 sub neg b", 2'd3, mk(0, 32), mk(1, 16), {mk(0, 41), 2'b00});
        op_chk("R8 sub larger b", 2'd3, mk(0, 16), mk(0, 32), {mk(1, 16), 2'b00});
    endtask

    task automatic t_range();
        op_chk("R9 d=span opposite", 2'd2, mk(0, 200), mk(1, 72), {mk(0, 200), 2'b00});
        op_chk("R9 d=span swapped", 2'd2, mk(0, 72), mk(0, 200), {mk(0, 200), 2'b00});
        op_mdl("R9 d=span-1", 2'd2, mk(0, 199), mk(1, 72));
        op_chk("R9 beyond span", 2'd2, mk(1, -100), mk(0, 150), {mk(0, 150), 2'b00});
    endtask

    task automatic t_zero_add();
        op_chk("R10 sub zero a", 2'd3, ZW, mk(1, -7), {mk(0, -7), 2'b00});
        op_chk("R10 add zero b", 2'd2, mk(1, 55), ZW, {mk(1, 55), 2'b00});
        op_chk("R10 both zero", 2'd3, ZW, ZW, {ZW, 2'b00});
    endtask

    task automatic t_sat();
        op_chk("R11 mul overflow", 2'd0, mk(0, 200), mk(0, 100), {mk(0, EMAX), 2'b10});
        op_chk("R11 mul underflow", 2'd0, mk(1, -200), mk(0, -100), {ZW, 2'b10});
        op_chk("R11 add overflow", 2'd2, mk(0, EMAX), mk(0, EMAX), {mk(0, EMAX), 2'b10});
        op_chk("R11 sub underflow", 2'd3, mk(0, -250), mk(0, -251), {ZW, 2'b10});
        op_chk("R11 div overflow", 2'd1, mk(0, 200), mk(1, -100), {mk(1, EMAX), 2'b10});
        op_chk("R11 at limit no sat", 2'd0, mk(0, 200), mk(0, 55), {mk(0, EMAX), 2'b00});
    endtask

    task automatic t_stream();
        logic [W+1:0] e0, e1, e2;
        e0 = {mk(0, 32), 2'b00};
        e1 = {mk(1, 16), 2'b00};
        e2 = {ZW, 2'b00};
        @(negedge clk);
        in_valid = 1'b1; in_op = 2'd0; in_a = mk(0, 16); in_b = mk(0, 16);
        @(negedge clk);
        in_op = 2'd1; in_a = mk(1, 24); in_b = mk(0, 8);
        @(negedge clk);
        in_op = 2'd2; in_a = mk(0, 9); in_b = mk(1, 9);
        chk("R12 stream 0", {out_valid, out_res, out_sat, out_div0}, {1'b1, e0});
        @(negedge clk);
        in_valid = 1'b0;
        chk("R12 stream 1", {out_valid, out_res, out_sat, out_div0}, {1'b1, e1});
        @(negedge clk);
        chk("R12 stream 2", {out_valid, out_res, out_sat, out_div0}, {1'b1, e2});
        @(negedge clk);
        chk("R12 idle after stream", {{(W+2){1'b0}}, out_valid}, '0);
    endtask

    task automatic t_sweep();
        int unsigned st;
        st = 32'h1234_5678;
        for (int k = 0; k < 400; k++) begin
            logic [1:0] op;
            int ea, eb;
            logic [W-1:0] a, b;
            st = st * 32'd1664525 + 32'd1013904223;
            op = st[31:30];
            ea = int'(st[27:19] % 9'd511) - 255;
            if (st[4]) eb = ea + int'(st[17:12] % 6'd41) - 20;
            else       eb = int'(st[15:7] % 9'd511) - 255;
            if (eb > EMAX)  eb = EMAX;
            if (eb < -EMAX) eb = -EMAX;
            a = mk(st[2], ea);
            b = mk(st[3], eb);
            if (st[11:8] == 4'd0) a = ZW;
            if (st[11:8] == 4'd1) b = ZW;
            case (op)
                2'd0: op_mdl("R3 sweep mul", op, a, b);
                2'd1: op_mdl("R4 sweep div", op, a, b);
                2'd2: op_mdl("R6 sweep add", op, a, b);
                default: op_mdl("R8 sweep sub", op, a, b);
            endcase
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R12 watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_opcodes();
        t_muldiv();
        t_zero_muldiv();
        t_add_same();
        t_add_opp();
        t_sub();
        t_range();
        t_zero_add();
        t_sat();
        t_stream();
        t_sweep();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule